// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block is the 32-bit datapath of a small multicycle processor. Each instruction runs over several clock cycles. One memory port serves both instruction fetch and data loads and stores. One ALU does the address arithmetic, the operations, the program-counter increment and the branch-target sum. Registers that software cannot see hold values from one step to the next: the instruction register, the memory data register, the two operand latches and the ALU output register.

An external sequencer drives every enable and steering select on each cycle. The datapath returns the instruction's opcode and function fields so the sequencer can decode them. It also returns a live zero flag from the ALU. The memory is a behavioural word array that is loaded from a parameter at reset.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter and the instruction register are zero, so opcode_o and funct_o read 0 and the first fetch reads word 0.
- R2: With addr_sel_i=0 and ir_we_i=1, the word at the program counter is loaded into the instruction register at the clock edge. In the next cycle opcode_o shows its bits 31:26 and funct_o shows its bits 5:0. With srca_sel_i=0, srcb_sel_i=1, alu_ctl_i=add, pc_sel_i=0 and pc_we_i=1, the program counter advances by 4 in the same edge.
- R3: While ir_we_i=0 the instruction register keeps its value, including during data-memory cycles.
- R4: With addr_sel_i=1 the memory is addressed by the ALU output register. Every edge loads the memory data register. With rf_we_i=1, wb_sel_i=1 and dst_sel_i=0, that data is written to register rt (bits 20:16).
- R5: With addr_sel_i=1 and mem_we_i=1, the B operand latch (register rt) is written to the word addressed by the ALU output register.
- R6: alu_ctl_i codes are 2 add, 6 subtract, 0 and, 1 or, 7 signed set-less-than. With rf_we_i=1, wb_sel_i=0 and dst_sel_i=1, the ALU output register is written to rd (bits 15:11).
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: srca_sel_i picks the program counter (0) or the A latch (1). srcb_sel_i picks the B latch (0), the constant 4 (1), the sign-extended 16-bit immediate (2), or that immediate shifted left by 2 (3).
- R9: pc_sel_i=1 loads the program counter from the ALU output register. The counter loads when pc_we_i=1, or when branch_i=1 and zero_o=1; otherwise it holds.
- R10: pc_sel_i=2 loads the program counter with {pc[31:28], instr[25:0], 2'b00}. pc_sel_i=0 loads it with the live ALU result.
- R11: zero_o is 1 exactly when the live ALU result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_we_i | input | 1 | Unconditional program-counter load |
| branch_i | input | 1 | Program-counter load when zero_o is 1 |
| ir_we_i | input | 1 | Instruction register load |
| addr_sel_i | input | 1 | Memory address: 0 program counter, 1 ALU output register |
| mem_we_i | input | 1 | Memory write |
| rf_we_i | input | 1 | Register file write |
| dst_sel_i | input | 1 | Write address: 0 rt, 1 rd |
| wb_sel_i | input | 1 | Write data: 0 ALU output register, 1 memory data register |
| srca_sel_i | input | 1 | ALU A operand select |
| srcb_sel_i | input | 2 | ALU B operand select |
| pc_sel_i | input | 2 | Next program-counter source |
| alu_ctl_i | input | 3 | ALU operation |
| opcode_o | output | 6 | Instruction register bits 31:26 |
| funct_o | output | 6 | Instruction register bits 5:0 |
| zero_o | output | 1 | Live ALU result equals zero |

## Verification
Every internal register shows up at the ports only through the fetched instruction fields or the zero flag. A wrong program counter shows up one cycle after the next fetch, as an unexpected opcode or function code in the decode step. A wrong register, latch or memory word shows up in the ALU cycle that uses it. The bench places probe words in the program. Each probe compares a register or the program counter against its immediate through the ALU, so a bad operand latch, sign extension, write-back or branch decision changes zero_o within about three cycles of the fault.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RIDX = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG   = 2'd0,
    SRCB_FOUR  = 2'd1,
    SRCB_IMM   = 2'd2,
    SRCB_IMMSH = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_ALU    = 2'd0,
    PCS_ALUOUT = 2'd1,
    PCS_JUMP   = 2'd2
  } pc_src_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   ctl_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (ctl_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile import mc_pkg::*; #(
  parameter int unsigned W        = XLEN,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic          we_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o
);
  logic [W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         regs_q[g] <= '0;
        else if (we_i && wa_i == AW'(g))     regs_q[g] <= wd_i;
      end
    end
  end

  assign rd1_o = regs_q[ra1_i];
  assign rd2_o = regs_q[ra2_i];
endmodule

// File: rtl/mc_mem.sv
module mc_mem import mc_pkg::*; #(
  parameter int unsigned W     = XLEN,
  parameter int unsigned WORDS = 64,
  parameter logic [WORDS*W-1:0] INIT = '0,
  localparam int unsigned MAW  = $clog2(WORDS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         we_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0]   mem_q [WORDS];
  logic [MAW-1:0] idx;
  logic           unused_addr;

  assign idx         = addr_i[MAW+1:2];
  assign unused_addr = ^{addr_i[W-1:MAW+2], addr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(WORDS); i++) mem_q[i] <= INIT[i*W +: W];
    end else if (we_i) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath import mc_pkg::*; #(
  parameter int unsigned MEM_WORDS = 64,
  parameter int unsigned NUM_REGS  = 32,
  parameter logic [MEM_WORDS*XLEN-1:0] MEM_INIT = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pc_we_i,
  input  logic       branch_i,
  input  logic       ir_we_i,
  input  logic       addr_sel_i,
  input  logic       mem_we_i,
  input  logic       rf_we_i,
  input  logic       dst_sel_i,
  input  logic       wb_sel_i,
  input  logic       srca_sel_i,
  input  logic [1:0] srcb_sel_i,
  input  logic [1:0] pc_sel_i,
  input  logic [2:0] alu_ctl_i,
  output logic [5:0] opcode_o,
  output logic [5:0] funct_o,
  output logic       zero_o
);
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] mem_addr, mem_rdata;
  logic [XLEN-1:0] rd1, rd2, wd;
  logic [XLEN-1:0] imm_ext, imm_sh, jump_tgt;
  logic [XLEN-1:0] srca, srcb, alu_y, pc_next;
  logic [RIDX-1:0] rs_addr, rt_addr, rd_addr, wa;
  logic            alu_zero, pc_en;
  logic            unused_shamt;

  assign rs_addr      = ir_q[25:21];
  assign rt_addr      = ir_q[20:16];
  assign rd_addr      = ir_q[15:11];
  assign unused_shamt = ^ir_q[10:6];

  // immediate is derived from the held instruction, not registered
  assign imm_ext  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_sh   = {imm_ext[XLEN-3:0], 2'b00};
  assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  assign mem_addr = addr_sel_i ? aluout_q : pc_q;

  mc_mem #(.W(XLEN), .WORDS(MEM_WORDS), .INIT(MEM_INIT)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (mem_addr),
    .wdata_i (b_q),
    .we_i    (mem_we_i),
    .rdata_o (mem_rdata)
  );

  assign wa = dst_sel_i ? rd_addr : rt_addr;
  assign wd = wb_sel_i  ? mdr_q   : aluout_q;

  mc_regfile #(.W(XLEN), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs_addr),
    .ra2_i  (rt_addr),
    .wa_i   (wa),
    .wd_i   (wd),
    .we_i   (rf_we_i),
    .rd1_o  (rd1),
    .rd2_o  (rd2)
  );

  assign srca = srca_sel_i ? a_q : pc_q;

  always_comb begin
    unique case (srcb_e'(srcb_sel_i))
      SRCB_REG:   srcb = b_q;
      SRCB_FOUR:  srcb = XLEN'(4);
      SRCB_IMM:   srcb = imm_ext;
      SRCB_IMMSH: srcb = imm_sh;
      default:    srcb = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a_i    (srca),
    .b_i    (srcb),
    .ctl_i  (alu_ctl_i),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  always_comb begin
    unique case (pc_src_e'(pc_sel_i))
      PCS_ALU:    pc_next = alu_y;
      PCS_ALUOUT: pc_next = aluout_q;
      PCS_JUMP:   pc_next = jump_tgt;
      default:    pc_next = alu_y;
    endcase
  end

  assign pc_en = pc_we_i | (branch_i & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)    pc_q <= pc_next;
      if (ir_we_i)  ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_y;
    end
  end

  assign opcode_o = ir_q[31:26];
  assign funct_o  = ir_q[5:0];
  assign zero_o   = alu_zero;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk import mc_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pc_we_i,
  input logic            branch_i,
  input logic            ir_we_i,
  input logic            addr_sel_i,
  input logic [1:0]      pc_sel_i,
  input logic            zero_o,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] aluout_q,
  input logic [XLEN-1:0] mem_rdata,
  input logic [RIDX-1:0] rs_addr,
  input logic [XLEN-1:0] rd1
);
  a_r3_ir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_we_i |=> $stable(ir_q));

  a_r2_ir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_we_i && !addr_sel_i) |=> ir_q == $past(mem_rdata));

  a_r9_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_we_i && !(branch_i && zero_o)) |=> $stable(pc_q));

  a_r9_br_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_we_i && branch_i && zero_o && pc_sel_i == 2'd1) |=> pc_q == $past(aluout_q));

  a_r10_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && pc_sel_i == 2'd2) |=> pc_q[27:0] == {$past(ir_q[25:0]), 2'b00});

  a_r7_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_addr == '0) |-> rd1 == '0);
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_we_i    (pc_we_i),
  .branch_i   (branch_i),
  .ir_we_i    (ir_we_i),
  .addr_sel_i (addr_sel_i),
  .pc_sel_i   (pc_sel_i),
  .zero_o     (zero_o),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .aluout_q   (aluout_q),
  .mem_rdata  (mem_rdata),
  .rs_addr    (rs_addr),
  .rd1        (rd1)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
  localparam int WORDS = 64;
  localparam logic [5:0] OP_R = 6'h00, OP_ADDI = 6'h08, OP_LW = 6'h23, OP_SW = 6'h2b;
  localparam logic [5:0] OP_BEQ = 6'h04, OP_J = 6'h02, OP_PRB = 6'h3f, OP_FILL = 6'h3e;
  localparam logic [5:0] F_ADD = 6'd32, F_SUB = 6'd34, F_AND = 6'd36, F_OR = 6'd37, F_SLT = 6'd42;
  localparam logic [2:0] A_AND = 3'd0, A_OR = 3'd1, A_ADD = 3'd2, A_SUB = 3'd6, A_SLT = 3'd7;

  function automatic logic [31:0] ei(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] er(int rs, int rt, int rd, logic [5:0] fn);
    return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] pw(int i);
    case (i)
      0:  return ei(OP_ADDI, 0, 1, 16'd5);
      1:  return ei(OP_ADDI, 0, 2, 16'hfffd);
      2:  return ei(OP_PRB, 2, 0, 16'hfffd);
      3:  return er(1, 2, 3, F_ADD);
      4:  return er(1, 2, 4, F_SUB);
      5:  return er(2, 1, 5, F_SLT);
      6:  return er(1, 2, 6, F_OR);
      7:  return er(1, 2, 9, F_AND);
      8:  return ei(OP_PRB, 3, 0, 16'd2);
      9:  return ei(OP_PRB, 4, 0, 16'd2);
      10: return ei(OP_PRB, 5, 0, 16'd1);
      11: return ei(OP_PRB, 6, 0, 16'hfffd);
      12: return ei(OP_PRB, 9, 0, 16'd5);
      13: return ei(OP_SW, 0, 4, 16'd160);
      14: return ei(OP_LW, 0, 7, 16'd160);
      15: return ei(OP_PRB, 7, 0, 16'd8);
      16: return ei(OP_ADDI, 0, 0, 16'd9);
      17: return ei(OP_PRB, 0, 0, 16'd0);
      18: return ei(OP_PRB, 0, 0, 16'd76);
      19: return ei(OP_BEQ, 1, 2, 16'd5);
      20: return ei(OP_PRB, 0, 0, 16'd84);
      21: return ei(OP_BEQ, 3, 3, 16'd2);
      24: return ei(OP_PRB, 0, 0, 16'd100);
      25: return {OP_J, 26'd30};
      30: return ei(OP_PRB, 0, 0, 16'd124);
      31: return ei(OP_PRB, 5, 0, 16'd0);
      32: return ei(OP_PRB, 1, 0, 16'd0);
      33: return ei(OP_PRB, 3, 0, 16'd3);
      22, 23, 26, 27, 28, 29: return ei(OP_FILL, 0, 0, 16'h003e);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [WORDS*32-1:0] build();
    logic [WORDS*32-1:0] v = '0;
    for (int i = 0; i < WORDS; i++) v[i*32 +: 32] = pw(i);
    return v;
  endfunction

  localparam logic [WORDS*32-1:0] PROG = build();

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pc_we_i, branch_i, ir_we_i, addr_sel_i, mem_we_i, rf_we_i, dst_sel_i, wb_sel_i, srca_sel_i;
  logic [1:0] srcb_sel_i, pc_sel_i;
  logic [2:0] alu_ctl_i;
  logic [5:0] opcode_o, funct_o;
  logic zero_o;

  always #5 clk_i = ~clk_i;

  mc_datapath #(.MEM_WORDS(WORDS), .NUM_REGS(32), .MEM_INIT(PROG)) u_dut (
    .clk_i, .rst_ni, .pc_we_i, .branch_i, .ir_we_i, .addr_sel_i, .mem_we_i, .rf_we_i,
    .dst_sel_i, .wb_sel_i, .srca_sel_i, .srcb_sel_i, .pc_sel_i, .alu_ctl_i,
    .opcode_o, .funct_o, .zero_o
  );

  typedef struct {
    string      req;
    bit         chk_ir;
    logic [5:0] op;
    logic [5:0] fn;
    bit         chk_z;
    logic       z;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor: compares each queued item mid low phase
  always @(negedge clk_i) begin
    #2;
    while (q.size() > 0) begin
      e = q.pop_front();
      if (e.chk_ir) begin
        checks++;
        if (opcode_o !== e.op || funct_o !== e.fn) begin
          errors++;
          $display("FAIL %s: opcode/funct %h/%h expected %h/%h", e.req, opcode_o, funct_o, e.op, e.fn);
        end
      end
      if (e.chk_z) begin
        checks++;
        if (zero_o !== e.z) begin
          errors++;
          $display("FAIL %s: zero %b expected %b", e.req, zero_o, e.z);
        end
      end
    end
  end

  task automatic push_ir(logic [5:0] op, logic [5:0] fn, string req);
    exp_t x;
    x.req = req; x.chk_ir = 1; x.op = op; x.fn = fn; x.chk_z = 0; x.z = 0;
    q.push_back(x);
  endtask

  task automatic push_z(logic z, string req);
    exp_t x;
    x.req = req; x.chk_ir = 0; x.op = '0; x.fn = '0; x.chk_z = 1; x.z = z;
    q.push_back(x);
  endtask

  task automatic idle();
    pc_we_i = 0; branch_i = 0; ir_we_i = 0; addr_sel_i = 0; mem_we_i = 0; rf_we_i = 0;
    dst_sel_i = 0; wb_sel_i = 0; srca_sel_i = 0; srcb_sel_i = 2'd0; pc_sel_i = 2'd0;
    alu_ctl_i = A_ADD;
  endtask

  task automatic fetch();
    @(negedge clk_i); idle();
    ir_we_i = 1; srcb_sel_i = 2'd1; pc_we_i = 1;
  endtask

  // decode: R2 fetched fields visible; ALUOut gets the branch target
  task automatic decode(int idx);
    logic [31:0] w = pw(idx);
    @(negedge clk_i); idle();
    srcb_sel_i = 2'd3;
    push_ir(w[31:26], w[5:0], "R2");
  endtask

  task automatic run_addi(int idx);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = 1; srcb_sel_i = 2'd2;
    @(negedge clk_i); idle(); rf_we_i = 1;
  endtask

  task automatic run_r(int idx, logic [2:0] op);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = 1; alu_ctl_i = op;
    @(negedge clk_i); idle(); rf_we_i = 1; dst_sel_i = 1;
  endtask

  task automatic run_sw(int idx);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = 1; srcb_sel_i = 2'd2;
    @(negedge clk_i); idle(); addr_sel_i = 1; mem_we_i = 1;
  endtask

  task automatic run_lw(int idx);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = 1; srcb_sel_i = 2'd2;
    @(negedge clk_i); idle(); addr_sel_i = 1;
    push_ir(OP_LW, pw(idx)[5:0], "R3");
    @(negedge clk_i); idle(); rf_we_i = 1; wb_sel_i = 1;
  endtask

  task automatic run_beq(int idx, logic z);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = 1; alu_ctl_i = A_SUB; pc_sel_i = 2'd1; branch_i = 1;
    push_z(z, "R9");
  endtask

  task automatic run_j(int idx);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); pc_sel_i = 2'd2; pc_we_i = 1;
  endtask

  task automatic probe(int idx, logic sa, logic [1:0] sb, logic [2:0] op, logic z, string req);
    fetch(); decode(idx);
    @(negedge clk_i); idle(); srca_sel_i = sa; srcb_sel_i = sb; alu_ctl_i = op;
    push_z(z, req);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    push_ir(6'd0, 6'd0, "R1");
    run_addi(0);
    run_addi(1);
    probe(2, 1, 2'd2, A_SUB, 1, "R8 sign-extended imm");
    run_r(3, A_ADD);
    run_r(4, A_SUB);
    run_r(5, A_SLT);
    run_r(6, A_OR);
    run_r(7, A_AND);
    probe(8,  1, 2'd2, A_SUB, 1, "R6 add");
    probe(9,  1, 2'd3, A_SUB, 1, "R8 imm<<2 / R6 sub");
    probe(10, 1, 2'd2, A_SUB, 1, "R6 slt");
    probe(11, 1, 2'd2, A_SUB, 1, "R6 or");
    probe(12, 1, 2'd2, A_SUB, 1, "R6 and");
    run_sw(13);
    run_lw(14);
    probe(15, 1, 2'd2, A_SUB, 1, "R4/R5 load after store");
    run_addi(16);
    probe(17, 1, 2'd2, A_SUB, 1, "R7 r0 stays zero");
    probe(18, 0, 2'd2, A_SUB, 1, "R2 pc increment");
    run_beq(19, 0);
    probe(20, 0, 2'd2, A_SUB, 1, "R9 not taken");
    run_beq(21, 1);
    probe(24, 0, 2'd2, A_SUB, 1, "R9 taken target");
    run_j(25);
    probe(30, 0, 2'd2, A_SUB, 1, "R10 jump target");
    probe(31, 1, 2'd1, A_AND, 1, "R8 const four");
    probe(32, 1, 2'd1, A_AND, 0, "R11 nonzero");
    probe(33, 1, 2'd2, A_SUB, 0, "R11 mismatch");
    @(negedge clk_i); idle();
    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule